// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block sets the serial clock timing of an I2C master. A divider ratio (system clocks per SCL period) is loaded with a strobe. It is encoded into a 32-bit timing word made of three parts: a power-of-two base prescaler exponent, a low-phase count and a high-phase count. The encoder reaches the prescaler by halving the ratio until it drops below 16. Any bits lost while halving round the result up, so the bus is never clocked faster than requested.

While enabled, a base tick fires once per 2^exponent system clocks. The SCL output is held low for a number of ticks, then released high for a number of ticks, and this repeats. Two strobes mark the tick that ends each phase. A newly loaded ratio is held pending and is applied only at the end of a whole SCL period, so the output never shows a shortened or stretched phase. When the block is disabled, SCL rests high and all counters clear.

Top module: `scl_timing_gen`

## Requirements
- R1: The exponent equals the number of halvings done while the working ratio is 16 or more. Every bit shifted out is ORed into a sticky flag, and the flag is added to the final value to give the reduced ratio.
- R2: The low count is (reduced ratio >> 1) − 1 and the high count is reduced ratio − low count − 2. The high count therefore equals the low count plus the reduced ratio's least significant bit. Loaded ratios must be 2 or more.
- R3: In the timing word, bits 19:16 hold the high count, bits 15:12 hold the low count and bits 3:0 hold the exponent. Bits 31:20 and 9:8 are ones and all other bits are zero. The word updates in the cycle after `load_i` is sampled high and is unchanged otherwise.
- R4: While enabled, `base_tick_o` pulses once every 2^exponent clocks. The first pulse comes in the 2^exponent-th enabled cycle.
- R5: SCL is low for (low count + 1) × 2^exponent clocks, starting in the first enabled cycle. It is then high for (high count + 1) × 2^exponent clocks, and the pattern repeats.
- R6: `lo_done_o` pulses for one clock in the last cycle of each low phase, and `hi_done_o` does the same for each high phase. Each strobe coincides with a base tick, and the two never pulse together.
- R7: A ratio loaded while enabled leaves the current SCL period intact. It takes effect from the next low phase. While disabled, a load takes effect at once.
- R8: When `enable_i` is low, `scl_o` is high and no tick or strobe is produced. The next enable restarts with a full low phase.
- R9: After reset, the timing word is 0xFFF00300 (all counts and the exponent zero), SCL is high and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_i | input | RATIO_W (16) | Requested system clocks per SCL period |
| load_i | input | 1 | Captures `ratio_i` into the pending timing |
| enable_i | input | 1 | Runs the SCL generator |
| timing_word_o | output | 32 | Packed timing word of the last loaded ratio |
| base_tick_o | output | 1 | Prescaler tick |
| scl_o | output | 1 | SCL level (1 = released high) |
| lo_done_o | output | 1 | Last cycle of a low phase |
| hi_done_o | output | 1 | Last cycle of a high phase |

## Verification
The assertions assume that every ratio captured by `load_i` is at least 2. A smaller ratio would underflow the low count and break the fixed relation between the high and low counts; a checker property flags any load outside this range. The bench keeps to this limit. Its vector table covers ratios from 2 to the full 16-bit maximum, including values where the sticky round-up carries the reduced ratio to exactly 16. The timed runs use ratios with small exponents, so every phase length is measured cycle by cycle within a short run.

// File: rtl/scl_timing_pkg.sv
// Shared types and constants for the SCL timing generator.
// Assumes 4-bit phase-count and exponent fields in a 32-bit word.
package scl_timing_pkg;

    localparam int          FIELD_W    = 4;
    localparam int          WORD_W     = 32;
    localparam int          HI_LSB     = 16;
    localparam int          LO_LSB     = 12;
    localparam int          EXP_LSB    = 0;
    localparam logic [31:0] WORD_FIXED = 32'hFFF0_0300;

    typedef logic [FIELD_W-1:0] field_t;

    typedef struct packed {
        field_t hi;
        field_t lo;
        field_t expo;
    } scl_timing_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    // Places the three fields over the fixed bit pattern.
    function automatic logic [WORD_W-1:0] pack_timing(input scl_timing_t t);
        logic [WORD_W-1:0] w;
        w = WORD_FIXED;
        w[HI_LSB  +: FIELD_W] = t.hi;
        w[LO_LSB  +: FIELD_W] = t.lo;
        w[EXP_LSB +: FIELD_W] = t.expo;
        return w;
    endfunction

endpackage

// File: rtl/scl_ratio_encoder.sv
// Converts a divider ratio into exponent, low count and high count.
// Purely combinational. Assumes ratio >= 2 and RATIO_W between 5 and 19.
module scl_ratio_encoder
    import scl_timing_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic [RATIO_W-1:0] ratio_i,
    output scl_timing_t        timing_o
);

    localparam int               MAX_EXP = RATIO_W - 4;
    localparam logic [RATIO_W-1:0] LIMIT = RATIO_W'(15);

    logic [RATIO_W-1:0] work;
    logic               sticky;
    field_t             expo;
    logic [4:0]         reduced;
    field_t             lo_cnt;
    logic [4:0]         hi_wide;

    // Halves the ratio until it fits in four bits, collecting lost bits.
    always_comb begin
        work   = ratio_i;
        sticky = 1'b0;
        expo   = '0;
        for (int i = 0; i < MAX_EXP; i++) begin
            if (work > LIMIT) begin
                sticky = sticky | work[0];
                work   = work >> 1;
                expo   = expo + field_t'(1);
            end
        end
    end

    // Rounds up and splits the reduced ratio into the two phase counts.
    always_comb begin
        reduced  = work[4:0] + {4'b0, sticky};
        lo_cnt   = reduced[4:1] - field_t'(1);
        hi_wide  = reduced - {1'b0, lo_cnt} - 5'd2;
        timing_o = '{hi: hi_wide[3:0], lo: lo_cnt, expo: expo};
    end

endmodule

// File: rtl/scl_base_ticker.sv
// Power-of-two prescaler: pulses tick_o once every 2^expo_i clocks.
// Assumes expo_i <= MAX_EXP. The count clears while run_i is low.
module scl_base_ticker
    import scl_timing_pkg::*;
#(
    parameter int MAX_EXP = 12
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  field_t expo_i,
    output logic   tick_o
);

    localparam int CNT_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] terminal;

    // Terminal count for the active exponent.
    always_comb begin
        terminal = (CNT_W'(1) << expo_i) - CNT_W'(1);
        tick_o   = run_i && (cnt_q == terminal);
    end

    // Counts clocks and wraps on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/scl_phase_gen.sv
// Alternates SCL between low and high phases measured in base ticks.
// Assumes the counts stay stable within a period. Rests in the low-phase start while idle.
module scl_phase_gen
    import scl_timing_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   run_i,
    input  logic   tick_i,
    input  field_t lo_cnt_i,
    input  field_t hi_cnt_i,
    output logic   scl_o,
    output logic   lo_done_o,
    output logic   hi_done_o
);

    scl_phase_e phase_q;
    field_t     ticks_q;

    // Phase-end strobes and the line level.
    always_comb begin
        lo_done_o = run_i && tick_i && (phase_q == PH_LOW)  && (ticks_q == lo_cnt_i);
        hi_done_o = run_i && tick_i && (phase_q == PH_HIGH) && (ticks_q == hi_cnt_i);
        scl_o     = !run_i || (phase_q == PH_HIGH);
    end

    // Advances the tick count and flips the phase at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= PH_LOW;
            ticks_q <= '0;
        end else if (lo_done_o) begin
            phase_q <= PH_HIGH;
            ticks_q <= '0;
        end else if (hi_done_o) begin
            phase_q <= PH_LOW;
            ticks_q <= '0;
        end else if (tick_i) begin
            ticks_q <= ticks_q + field_t'(1);
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
// Top of the SCL timing generator. It encodes a loaded ratio into pending
// timing and promotes it to active timing at period ends or while idle.
// Assumes every loaded ratio is at least 2.
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               load_i,
    input  logic               enable_i,
    output logic [31:0]        timing_word_o,
    output logic               base_tick_o,
    output logic               scl_o,
    output logic               lo_done_o,
    output logic               hi_done_o
);

    localparam int MAX_EXP = RATIO_W - 4;

    scl_timing_t enc_timing;
    scl_timing_t pend_q;
    scl_timing_t act_q;

    scl_ratio_encoder #(.RATIO_W(RATIO_W)) u_enc (
        .ratio_i  (ratio_i),
        .timing_o (enc_timing)
    );

    // Holds the most recently loaded timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load_i) begin
            pend_q <= enc_timing;
        end
    end

    // Promotes pending timing only at a period boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (!enable_i || hi_done_o) begin
            act_q <= pend_q;
        end
    end

    scl_base_ticker #(.MAX_EXP(MAX_EXP)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (enable_i),
        .expo_i (act_q.expo),
        .tick_o (base_tick_o)
    );

    scl_phase_gen u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (enable_i),
        .tick_i    (base_tick_o),
        .lo_cnt_i  (act_q.lo),
        .hi_cnt_i  (act_q.hi),
        .scl_o     (scl_o),
        .lo_done_o (lo_done_o),
        .hi_done_o (hi_done_o)
    );

    // Presents the pending timing as the packed word.
    always_comb begin
        timing_word_o = pack_timing(pend_q);
    end

endmodule

// File: rtl/scl_timing_checker.sv
// Protocol properties of the SCL timing generator, bound to the top.
module scl_timing_checker #(
    parameter int RATIO_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               load_i,
    input logic               enable_i,
    input logic [31:0]        timing_word_o,
    input logic               base_tick_o,
    input logic               scl_o,
    input logic               lo_done_o,
    input logic               hi_done_o,
    input logic [11:0]        act_word
);

    AST_RATIO_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (ratio_i >= RATIO_W'(2)));                                  // R2
    AST_EXP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        timing_word_o[3:0] <= 4'(RATIO_W - 4));                                // R1
    AST_HI_LO_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_word_o[19:16] == timing_word_o[15:12]) ||
        (timing_word_o[19:16] == timing_word_o[15:12] + 4'd1));                // R2
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load_i) |-> $stable(timing_word_o));                            // R3
    AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick_o |-> enable_i);                                             // R4
    AST_RISE_AFTER_LOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_o) && enable_i && $past(enable_i)) |-> $past(lo_done_o));   // R5
    AST_FALL_AFTER_HIGH_END: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_o) && enable_i && $past(enable_i)) |-> $past(hi_done_o));   // R5
    AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_done_o || hi_done_o) |-> base_tick_o);                             // R6
    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(lo_done_o && hi_done_o));                                            // R6
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && $past(enable_i) && !$past(hi_done_o)) |-> $stable(act_word)); // R7
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> (scl_o && !lo_done_o && !hi_done_o));                    // R8

endmodule

bind scl_timing_gen scl_timing_checker #(.RATIO_W(RATIO_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ratio_i       (ratio_i),
    .load_i        (load_i),
    .enable_i      (enable_i),
    .timing_word_o (timing_word_o),
    .base_tick_o   (base_tick_o),
    .scl_o         (scl_o),
    .lo_done_o     (lo_done_o),
    .hi_done_o     (hi_done_o),
    .act_word      (act_q)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ratio_i = '0;
    logic        load_i = 1'b0;
    logic        enable_i = 1'b0;
    logic [31:0] timing_word_o;
    logic        base_tick_o, scl_o, lo_done_o, hi_done_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    scl_timing_gen #(.RATIO_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .ratio_i(ratio_i), .load_i(load_i),
        .enable_i(enable_i), .timing_word_o(timing_word_o),
        .base_tick_o(base_tick_o), .scl_o(scl_o),
        .lo_done_o(lo_done_o), .hi_done_o(hi_done_o)
    );

    // Ratio and expected word, worked out by hand from R1, R2 and R3.
    localparam int NVEC = 10;
    localparam logic [47:0] VEC [NVEC] = '{
        {16'd2,     32'hFFF0_0300},
        {16'd3,     32'hFFF1_0300},
        {16'd5,     32'hFFF2_1300},
        {16'd15,    32'hFFF7_6300},
        {16'd16,    32'hFFF3_3301},
        {16'd31,    32'hFFF7_7301},
        {16'd33,    32'hFFF4_3302},
        {16'd100,   32'hFFF6_5303},
        {16'd1000,  32'hFFF7_7306},
        {16'hFFFF,  32'hFFF7_730C}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_ratio(input logic [15:0] r);
        @(posedge clk); #1 ratio_i = r; load_i = 1'b1;
        @(posedge clk); #1 load_i = 1'b0;
    endtask

    // Counts one low phase then one high phase, sampling at falling edges.
    task automatic measure(input int pre, output int lo_len, output int hi_len,
                           output int lo_at, output int hi_at,
                           output int ticks, output int first_tick);
        int n;
        n = pre; lo_at = -1; hi_at = -1; ticks = 0; first_tick = -1;
        while (1) begin
            @(negedge clk);
            if (scl_o) break;
            n++;
            if (lo_done_o) lo_at = n;
            if (base_tick_o) begin
                ticks++;
                if (first_tick < 0) first_tick = n;
            end
        end
        lo_len = n;
        n = 1;
        if (hi_done_o) hi_at = 1;
        while (1) begin
            @(negedge clk);
            if (!scl_o) break;
            n++;
            if (hi_done_o) hi_at = n;
        end
        hi_len = n;
    endtask

    task automatic timed_run(input logic [15:0] r, input int lo_exp, input int hi_exp,
                             input int tick_exp);
        int lo_len, hi_len, lo_at, hi_at, ticks, first_tick;
        load_ratio(r);
        @(posedge clk); #1 enable_i = 1'b1;
        measure(0, lo_len, hi_len, lo_at, hi_at, ticks, first_tick);
        chk("R5 low length", lo_len, lo_exp);
        chk("R5 high length", hi_len, hi_exp);
        chk("R6 lo_done position", lo_at, lo_exp);
        chk("R6 hi_done position", hi_at, hi_exp);
        chk("R4 first tick", first_tick, tick_exp);
        chk("R4 ticks in low phase", ticks, lo_exp / tick_exp);
        @(posedge clk); #1 enable_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lo_len, hi_len, lo_at, hi_at, ticks, first_tick;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset word", timing_word_o, 32'hFFF0_0300);
        chk("R9 reset scl", {31'b0, scl_o}, 32'd1);
        chk("R9 reset strobes", {29'b0, base_tick_o, lo_done_o, hi_done_o}, 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // Table walk: R1 R2 R3 encoding.
        for (int i = 0; i < NVEC; i++) begin
            load_ratio(VEC[i][47:32]);
            @(negedge clk);
            chk("R1 R2 R3 word", timing_word_o, VEC[i][31:0]);
        end

        // R3: ratio changes without load leave the word unchanged.
        @(posedge clk); #1 ratio_i = 16'd5;
        repeat (2) @(negedge clk);
        chk("R3 hold without load", timing_word_o, 32'hFFF7_730C);

        // R4 R5 R6: phase lengths at several exponents.
        timed_run(16'd5, 2, 3, 1);
        timed_run(16'd2, 1, 1, 1);
        timed_run(16'd16, 8, 8, 2);
        timed_run(16'd33, 16, 20, 4);

        // R7: reload in mid-period keeps this period, applies on the next.
        load_ratio(16'd16);
        @(posedge clk); #1 enable_i = 1'b1;
        fork
            measure(0, lo_len, hi_len, lo_at, hi_at, ticks, first_tick);
            begin
                repeat (3) @(posedge clk);
                #1 ratio_i = 16'd5; load_i = 1'b1;
                @(posedge clk); #1 load_i = 1'b0;
            end
        join
        chk("R7 current low kept", lo_len, 8);
        chk("R7 current high kept", hi_len, 8);
        chk("R3 word after mid load", timing_word_o, 32'hFFF2_1300);
        measure(1, lo_len, hi_len, lo_at, hi_at, ticks, first_tick);
        chk("R7 next low uses new ratio", lo_len, 2);
        chk("R7 next high uses new ratio", hi_len, 3);

        // R8: disable during a high phase, then restart.
        @(posedge clk); #1 enable_i = 1'b0;
        load_ratio(16'd16);
        @(posedge clk); #1 enable_i = 1'b1;
        while (!scl_o) @(negedge clk);
        repeat (2) @(negedge clk);
        @(posedge clk); #1 enable_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R8 idle outputs", {28'b0, scl_o, base_tick_o, lo_done_o, hi_done_o}, 32'h8);
        end
        @(posedge clk); #1 enable_i = 1'b1;
        measure(0, lo_len, hi_len, lo_at, hi_at, ticks, first_tick);
        chk("R8 restart low full", lo_len, 8);
        chk("R8 restart high full", hi_len, 8);
        @(posedge clk); #1 enable_i = 1'b0;

        repeat (2) @(posedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule